// File: doc/BRIEF.md
# Chip-Select Bank Decoder with Priority

This block sits between a CPU access port and an external memory bus. It splits a 64 MB, 26-bit address space into ten banks of mixed size and decides which of four external chip-select lines serves the addressed bank. Two software-visible area-select registers hold one bank mask per chip select. When several masks claim the same bank, a fixed priority keeps exactly one select.

An accepted request runs a short external bus cycle. The block drives a one-cycle setup phase, then a read or write strobe phase, then a one-cycle hold phase. The strobe phase lasts longer for every cycle in which the external wait input is sampled high. The low 24 address bits and the four byte enables are driven off-chip. A request whose bank is claimed by no select finishes at once with an error flag and touches no external line.

The four select outputs are numbered 0, 1, 3 and 4 off-chip; there is no select 2. Inside the block they are packed into a 4-bit vector in that order.

Top module: `cs_bank_decoder`

## Requirements
- R1: After synchronous reset, both area-select registers are zero, `cs_o`, `rd_o`, `wr_o`, `done_o` and `err_o` are low, and `req_ready` is high.
- R2: A write with `reg_sel`=0 sets the select-0 mask from data bits 9:0 and the select-1 mask from bits 25:16; `reg_sel`=1 does the same for select 3 (bits 9:0) and select 4 (bits 25:16). `reg_rdata` shows the register chosen by `reg_sel` one cycle later, and all other bits read as zero.
- R3: Banks from address 0 upward are 2 MB, 2 MB, 4 MB and then seven banks of 8 MB. Bank k corresponds to bit k of every mask.
- R4: `cs_o` bit 0 drives select 0, bit 1 drives select 1, bit 2 drives select 3 and bit 3 drives select 4. A bit is raised only when its mask covers the addressed bank.
- R5: When several masks cover the bank, only one select is raised, in the order select 0 > select 1 > select 3 > select 4.
- R6: A request to a bank that no mask covers raises no select and no strobe. `done_o` and `err_o` pulse together in the cycle after acceptance.
- R7: `ext_addr` equals request address bits 23:0 and `be_o` equals the request byte mask. Both values, and `cs_o`, stay stable from the setup phase through the hold phase.
- R8: An access has one setup cycle with both strobes low, then a strobe phase with `rd_o` high for a read or `wr_o` high for a write, then one hold cycle with both strobes low. `done_o` pulses with `err_o` low in the cycle after the hold cycle, and `cs_o` is low at that point.
- R9: The strobe phase lasts one cycle plus one more cycle for each consecutive strobe cycle in which `wait_i` is sampled high.
- R10: While `req_ready` is low, new requests are ignored. A register write made during an access does not change the select of that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Area-select register write strobe |
| reg_sel | input | 1 | Register index: 0 = selects 0/1, 1 = selects 3/4 |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data of the chosen register |
| req_valid | input | 1 | CPU access request |
| req_addr | input | 26 | CPU byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 4 | Byte mask of the access |
| req_ready | output | 1 | Block is idle and accepts a request |
| wait_i | input | 1 | External wait, sampled in the strobe phase |
| cs_o | output | 4 | Chip selects (bits: select 0, 1, 3, 4), active high |
| ext_addr | output | 24 | External address |
| be_o | output | 4 | External byte enables, active high |
| rd_o | output | 1 | Read strobe, active high |
| wr_o | output | 1 | Write strobe, active high |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Completion with no select, valid with `done_o` |

## Verification
The assertions assume that the address never leaves the 64 MB decoded range. They also assume that `wait_i` has a defined value whenever the block is in its strobe phase, because the stretch property reads it there. The bench drives every input to a known value before reset is released and keeps all addresses inside the ten banks. It toggles `wait_i` only in strobe cycles and pulls it low again before the hold phase. It raises a request during a running access only to show that the request is ignored.

// File: rtl/csd_pkg.sv
package csd_pkg;

  // Smallest bank granule: 2 MB.
  localparam longint unsigned CSD_UNIT = 64'd1 << 21;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_t;

  // Lower boundary of bank b; bank b spans [bank_base(b), bank_base(b+1)).
  function automatic longint unsigned bank_base(input int b);
    if (b <= 0)      return 64'd0;
    else if (b == 1) return CSD_UNIT;
    else if (b == 2) return 2 * CSD_UNIT;
    else             return longint'(b - 2) * 4 * CSD_UNIT;
  endfunction

endpackage

// File: rtl/csd_regs.sv
module csd_regs #(
  parameter int NUM_BANKS = 10,
  parameter int REG_W     = 32,
  parameter int HI_LSB    = 16,
  parameter int NUM_CS    = 4
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 wr_en,
  input  logic                                 sel,
  input  logic [REG_W-1:0]                     wdata,
  output logic [REG_W-1:0]                     rdata,
  output logic [NUM_CS-1:0][NUM_BANKS-1:0]     cs_mask
);

  localparam int NUM_REGS = NUM_CS / 2;
  localparam int GAP_LO   = HI_LSB - NUM_BANKS;
  localparam int GAP_HI   = REG_W - HI_LSB - NUM_BANKS;

  logic [NUM_REGS-1:0][NUM_BANKS-1:0] lo_q;
  logic [NUM_REGS-1:0][NUM_BANKS-1:0] hi_q;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        lo_q[r] <= '0;
        hi_q[r] <= '0;
      end else if (wr_en && (int'(sel) == r)) begin
        lo_q[r] <= wdata[NUM_BANKS-1:0];
        hi_q[r] <= wdata[HI_LSB +: NUM_BANKS];
      end
    end
    assign cs_mask[2*r]   = lo_q[r];
    assign cs_mask[2*r+1] = hi_q[r];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= {{GAP_HI{1'b0}}, hi_q[sel], {GAP_LO{1'b0}}, lo_q[sel]};
    end
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rdata[HI_LSB-1:NUM_BANKS] == '0) && (rdata[REG_W-1:HI_LSB+NUM_BANKS] == '0)); // R2

endmodule

// File: rtl/csd_bank_map.sv
module csd_bank_map
  import csd_pkg::*;
#(
  parameter int ADDR_W    = 26,
  parameter int NUM_BANKS = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_BANKS-1:0] bank_hit
);

  localparam int CMP_W = ADDR_W + 1;

  logic [CMP_W-1:0] addr_x;
  assign addr_x = {1'b0, addr};

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [CMP_W-1:0] LO = CMP_W'(bank_base(b));
    localparam logic [CMP_W-1:0] HI = CMP_W'(bank_base(b + 1));
    assign bank_hit[b] = (addr_x >= LO) && (addr_x < HI);
  end

  AST_ONE_BANK: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_hit)); // R3

endmodule

// File: rtl/csd_prio.sv
module csd_prio #(
  parameter int NUM_BANKS = 10,
  parameter int NUM_CS    = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_CS-1:0][NUM_BANKS-1:0] cs_mask,
  input  logic [NUM_BANKS-1:0]             bank_hit,
  output logic [NUM_CS-1:0]                grant
);

  logic [NUM_CS-1:0] claim;

  for (genvar c = 0; c < NUM_CS; c++) begin : g_claim
    assign claim[c] = |(cs_mask[c] & bank_hit);
  end

  // Lowest index wins: select 0, then 1, then 3, then 4.
  always_comb begin
    grant = '0;
    for (int c = NUM_CS - 1; c >= 0; c--) begin
      if (claim[c]) begin
        grant    = '0;
        grant[c] = 1'b1;
      end
    end
  end

  AST_GRANT_ONE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)); // R5
  AST_GRANT_CLAIMED: assert property (@(posedge clk) disable iff (rst)
    (grant & ~claim) == '0); // R4
  AST_GRANT_FOUND: assert property (@(posedge clk) disable iff (rst)
    (claim != '0) |-> (grant != '0)); // R5

endmodule

// File: rtl/csd_strobe.sv
module csd_strobe
  import csd_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int EXT_W  = 24,
  parameter int BE_W   = 4,
  parameter int NUM_CS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [BE_W-1:0]   req_be,
  input  logic [NUM_CS-1:0] grant,
  input  logic              wait_i,
  output logic              req_ready,
  output logic [NUM_CS-1:0] cs_o,
  output logic [EXT_W-1:0]  ext_addr,
  output logic [BE_W-1:0]   be_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic              done_o,
  output logic              err_o
);

  phase_t phase_q;
  logic   write_q;

  assign req_ready = (phase_q == PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_IDLE;
      write_q  <= 1'b0;
      cs_o     <= '0;
      ext_addr <= '0;
      be_o     <= '0;
      rd_o     <= 1'b0;
      wr_o     <= 1'b0;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (req_valid) begin
            if (grant != '0) begin
              phase_q  <= PH_SETUP;
              cs_o     <= grant;
              ext_addr <= req_addr[EXT_W-1:0];
              be_o     <= req_be;
              write_q  <= req_write;
            end else begin
              done_o <= 1'b1;
              err_o  <= 1'b1;
            end
          end
        end
        PH_SETUP: begin
          phase_q <= PH_STROBE;
          rd_o    <= ~write_q;
          wr_o    <= write_q;
        end
        PH_STROBE: begin
          if (!wait_i) begin
            phase_q <= PH_HOLD;
            rd_o    <= 1'b0;
            wr_o    <= 1'b0;
          end
        end
        PH_HOLD: begin
          phase_q <= PH_IDLE;
          cs_o    <= '0;
          be_o    <= '0;
          done_o  <= 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cs_o)); // R5
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rd_o && wr_o)); // R8
  AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (rst)
    (rd_o || wr_o) |-> (cs_o != '0)); // R8
  AST_HELD_FIELDS: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_SETUP || phase_q == PH_STROBE) |=>
      ($stable(cs_o) && $stable(ext_addr) && $stable(be_o))); // R7
  AST_WAIT_STRETCH: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_STROBE && wait_i) |=> (rd_o || wr_o)); // R9
  AST_ERR_NO_CS: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (done_o && cs_o == '0 && !rd_o && !wr_o)); // R6
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && !$past(req_ready)) |-> !done_o || phase_q == PH_IDLE); // R10

endmodule

// File: rtl/cs_bank_decoder.sv
module cs_bank_decoder
  import csd_pkg::*;
#(
  parameter int ADDR_W    = 26,
  parameter int EXT_W     = 24,
  parameter int BE_W      = 4,
  parameter int NUM_BANKS = 10,
  parameter int NUM_CS    = 4,
  parameter int REG_W     = 32,
  parameter int HI_LSB    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [BE_W-1:0]   req_be,
  output logic              req_ready,
  input  logic              wait_i,
  output logic [NUM_CS-1:0] cs_o,
  output logic [EXT_W-1:0]  ext_addr,
  output logic [BE_W-1:0]   be_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic              done_o,
  output logic              err_o
);

  logic [NUM_CS-1:0][NUM_BANKS-1:0] cs_mask;
  logic [NUM_BANKS-1:0]             bank_hit;
  logic [NUM_CS-1:0]                grant;

  csd_regs #(
    .NUM_BANKS(NUM_BANKS), .REG_W(REG_W), .HI_LSB(HI_LSB), .NUM_CS(NUM_CS)
  ) i_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .sel(reg_sel),
    .wdata(reg_wdata), .rdata(reg_rdata), .cs_mask(cs_mask)
  );

  csd_bank_map #(
    .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)
  ) i_map (
    .clk(clk), .rst(rst), .addr(req_addr), .bank_hit(bank_hit)
  );

  csd_prio #(
    .NUM_BANKS(NUM_BANKS), .NUM_CS(NUM_CS)
  ) i_prio (
    .clk(clk), .rst(rst), .cs_mask(cs_mask), .bank_hit(bank_hit), .grant(grant)
  );

  csd_strobe #(
    .ADDR_W(ADDR_W), .EXT_W(EXT_W), .BE_W(BE_W), .NUM_CS(NUM_CS)
  ) i_strobe (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_be(req_be), .grant(grant), .wait_i(wait_i),
    .req_ready(req_ready), .cs_o(cs_o), .ext_addr(ext_addr), .be_o(be_o),
    .rd_o(rd_o), .wr_o(wr_o), .done_o(done_o), .err_o(err_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (cs_o == '0 && !rd_o && !wr_o && !done_o && req_ready)); // R1

endmodule

// File: tb/test_cs_bank_decoder.sv
module test_cs_bank_decoder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic [25:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [3:0]  req_be = '0;
  logic        req_ready;
  logic        wait_i = 1'b0;
  logic [3:0]  cs_o;
  logic [23:0] ext_addr;
  logic [3:0]  be_o;
  logic        rd_o, wr_o, done_o, err_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [9:0] m [4];

  always #4 clk = ~clk;

  cs_bank_decoder i_cs_bank_decoder (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .req_write(req_write), .req_be(req_be),
    .req_ready(req_ready), .wait_i(wait_i), .cs_o(cs_o), .ext_addr(ext_addr),
    .be_o(be_o), .rd_o(rd_o), .wr_o(wr_o), .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int bank_of(input logic [25:0] a);
    if (a < 26'h020_0000) return 0;
    if (a < 26'h040_0000) return 1;
    if (a < 26'h080_0000) return 2;
    return 2 + int'(a >> 23);
  endfunction

  function automatic logic [3:0] exp_cs(input logic [25:0] a);
    int b = bank_of(a);
    for (int c = 0; c < 4; c++) if (m[c][b]) return 4'(1 << c);
    return 4'b0000;
  endfunction

  task automatic reg_write(input bit s, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
    if (s) begin m[2] = d[9:0]; m[3] = d[25:16]; end
    else   begin m[0] = d[9:0]; m[1] = d[25:16]; end
  endtask

  task automatic reg_read_check(input bit s, input logic [31:0] exp);
    @(negedge clk); reg_sel = s;
    @(negedge clk);
    chk(reg_rdata == exp, "R2", "register readback", reg_rdata, exp);
  endtask

  task automatic test_reset;
    chk(cs_o == 0 && !rd_o && !wr_o, "R1", "outputs idle after reset", {cs_o, rd_o, wr_o}, 0);
    chk(req_ready && !done_o && !err_o, "R1", "ready after reset", {req_ready, done_o, err_o}, 3'b100);
    reg_read_check(1'b0, 32'h0);
    reg_read_check(1'b1, 32'h0);
  endtask

  task automatic test_regs;
    reg_write(1'b0, 32'hFFFF_FFFF);
    reg_read_check(1'b0, 32'h03FF_03FF);
    reg_write(1'b1, 32'hA5A5_5A5A);
    reg_read_check(1'b1, 32'h01A5_025A);
    reg_read_check(1'b0, 32'h03FF_03FF);
  endtask

  task automatic run_access(input string req, input logic [25:0] a, input bit wr,
                            input logic [3:0] be, input int waits);
    logic [3:0] ecs;
    int n;
    ecs = exp_cs(a);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    if (ecs == 0) begin
      chk(done_o && err_o, "R6", "error completion", {done_o, err_o}, 2'b11);
      chk(cs_o == 0 && !rd_o && !wr_o, "R6", "nothing driven on miss", {cs_o, rd_o, wr_o}, 0);
      return;
    end
    chk(cs_o == ecs, req, "select in setup", cs_o, ecs);
    chk(ext_addr == a[23:0] && be_o == be, "R7", "addr/be in setup", ext_addr, a[23:0]);
    chk(!rd_o && !wr_o && !done_o, "R8", "setup strobes low", {rd_o, wr_o, done_o}, 0);
    n = 0;
    @(negedge clk);
    while ((rd_o || wr_o) && n < 40) begin
      n++;
      chk(rd_o == !wr && wr_o == wr, "R8", "strobe kind", {rd_o, wr_o}, {!wr, wr});
      chk(cs_o == ecs && ext_addr == a[23:0] && be_o == be, "R7", "held in strobe", cs_o, ecs);
      wait_i = (n <= waits);
      @(negedge clk);
    end
    wait_i = 1'b0;
    chk(n == waits + 1, "R9", "strobe length", n, waits + 1);
    chk(cs_o == ecs && !rd_o && !wr_o && !done_o, "R8", "hold phase", {cs_o, rd_o, wr_o}, {ecs, 2'b00});
    @(negedge clk);
    chk(done_o && !err_o && cs_o == 0, "R8", "completion", {done_o, err_o, cs_o}, 6'b100000);
  endtask

  task automatic test_busy;
    logic [25:0] a;
    a = 26'h000_0040;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = 1'b0; req_be = 4'hF;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(rd_o && cs_o == 4'b0001 && !req_ready, "R10", "in strobe", {rd_o, cs_o}, 5'b10001);
    req_valid = 1'b1; req_addr = 26'h040_0000; req_write = 1'b1;
    reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 32'h0;
    wait_i = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; reg_wr = 1'b0; wait_i = 1'b0;
    m[0] = '0; m[1] = '0;
    chk(rd_o && !wr_o && cs_o == 4'b0001, "R10", "request and reg write ignored", {rd_o, wr_o, cs_o}, 6'b100001);
    chk(ext_addr == a[23:0], "R10", "address unchanged", ext_addr, a[23:0]);
    @(negedge clk);
    chk(cs_o == 4'b0001 && !rd_o, "R10", "hold keeps select", cs_o, 4'b0001);
    @(negedge clk);
    chk(done_o && !err_o && cs_o == 0, "R10", "single completion", {done_o, err_o}, 2'b10);
    @(negedge clk);
    chk(!done_o && cs_o == 0, "R10", "no second access", {done_o, cs_o}, 0);
  endtask

  initial begin
    for (int c = 0; c < 4; c++) m[c] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_regs();
    // selects 0/1: bank0,bank3 | bank1,bank3 ; selects 3/4: bank2,bank9 | bank2,bank5,bank9
    reg_write(1'b0, {6'd0, 10'b00_0000_1010, 6'd0, 10'b00_0000_1001});
    reg_write(1'b1, {6'd0, 10'b10_0010_0100, 6'd0, 10'b10_0000_0100});
    run_access("R4", 26'h000_0100, 1'b0, 4'hF, 0);
    run_access("R3", 26'h03F_FFFC, 1'b1, 4'h3, 2);
    run_access("R5", 26'h080_0000, 1'b0, 4'h1, 0);
    run_access("R5", 26'h07F_FFFC, 1'b1, 4'hC, 1);
    run_access("R4", 26'h180_0010, 1'b1, 4'h8, 3);
    run_access("R6", 26'h100_0000, 1'b0, 4'hF, 0);
    run_access("R3", 26'h3FF_FFFC, 1'b0, 4'hF, 0);
    reg_write(1'b0, {6'd0, 10'b00_0000_1010, 6'd0, 10'b00_0000_0000});
    run_access("R5", 26'h0FF_FFF0, 1'b0, 4'h6, 1);
    reg_write(1'b1, {6'd0, 10'b10_0010_0100, 6'd0, 10'b00_0000_0000});
    run_access("R5", 26'h3C0_0000, 1'b1, 4'hF, 0);
    reg_write(1'b0, {6'd0, 10'b00_0000_0000, 6'd0, 10'b00_0000_0001});
    test_busy();
    run_access("R6", 26'h000_0040, 1'b0, 4'hF, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule